// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address stream for a four-beat burst on a synchronous, pipelined memory interface of the SRAM kind. A load strobe captures a full starting address. Each later advance strobe moves the burst on by one beat. Only the lowest two address bits change during a burst. The higher bits are held at the captured value until the next load.

Two beat orderings are offered, and the choice is taken when the load happens. In linear order the low offset counts up by one per beat and wraps modulo four. In interleaved order the low offset is the start offset XOR the beat index. Both orderings put the supplied start offset on the bus as the first beat.

A last-beat flag marks the fourth beat. If the burst is advanced past that beat, the address returns to the first beat and the sequence repeats. The address field width and the offset width are parameters. With the default offset width of 2, a burst has four beats.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted and after it is released, `addr_out` is all zeros and `last_beat` is 0 until the first load.
- R2: On a clock edge where `load` is 1, the design captures the whole of `addr_in`. The following cycle shows `addr_out == addr_in` and beat index 0, whichever mode is selected.
- R3: With `lin_mode` = 0 at load (interleaved), the low offset at beat b is `start ^ b`. Starting at 01 this gives 01,00,11,10. Starting at 10 this gives 10,11,00,01.
- R4: With `lin_mode` = 1 at load (linear), the low offset at beat b is `(start + b) mod 4`. Starting at 01 this gives 01,10,11,00. Starting at 11 this gives 11,00,01,10.
- R5: Address bits above bit 1 keep the value captured at load until the next load, through every advance.
- R6: When `load` and `advance` are both 1 on the same edge, the load wins. The next cycle shows the new start address at beat 0.
- R7: An advance before the first load after reset has no effect. A cycle with neither strobe leaves `addr_out` and `last_beat` unchanged.
- R8: An advance on the fourth beat (beat index 3) returns the address to the start address, with beat index 0.
- R9: `last_beat` is 1 exactly when a burst has been loaded and its beat index is 3.
- R10: `lin_mode` is sampled only on a load. Changing it during a burst does not change the ordering of that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| load | input | 1 | Capture `addr_in` and start a burst |
| advance | input | 1 | Step to the next beat of the active burst |
| lin_mode | input | 1 | Ordering selected at load: 1 linear, 0 interleaved |
| addr_in | input | ADDR_W | Starting address of a burst |
| addr_out | output | ADDR_W | Current burst address |
| last_beat | output | 1 | High on beat index 3 |

## Verification
Every start offset from 0 to 3 is run in both orderings. Each burst is advanced through all four beats and one step beyond them, so each offset and mode is checked against both the XOR and the add-with-wrap formula, and the wrap back to the start is seen.

The upper address bits carry alternating patterns that differ between bursts. A corrupted upper bit, or one left over from a previous burst, therefore shows up at once. Two further patterns test control behaviour:
- toggling `lin_mode` in the middle of a burst separates sampling the mode at load from reading it live;
- a load and an advance on the same edge, and advances before any load, separate correct priority and gating from a counter that steps anyway.

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int ADDR_W = 20,
  parameter int OFS_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              advance,
  input  logic              lin_mode,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic              last_beat
);
  localparam int HI_W = ADDR_W - OFS_W;
  localparam logic [OFS_W-1:0] LAST_IDX = {OFS_W{1'b1}};

  logic [HI_W-1:0]  hi_q;
  logic [OFS_W-1:0] start_q;
  logic [OFS_W-1:0] beat_q;
  logic             lin_q;
  logic             busy_q;
  logic [OFS_W-1:0] ofs;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q    <= '0;
      start_q <= '0;
      beat_q  <= '0;
      lin_q   <= 1'b0;
      busy_q  <= 1'b0;
    end else if (load) begin
      hi_q    <= addr_in[ADDR_W-1:OFS_W];
      start_q <= addr_in[OFS_W-1:0];
      beat_q  <= '0;
      lin_q   <= lin_mode;
      busy_q  <= 1'b1;
    end else if (advance && busy_q) begin
      beat_q  <= beat_q + 1'b1;
    end
  end

  assign ofs       = lin_q ? start_q + beat_q : start_q ^ beat_q;
  assign addr_out  = {hi_q, ofs};
  assign last_beat = busy_q && (beat_q == LAST_IDX);
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W = 20,
  parameter int OFS_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load,
  input logic              advance,
  input logic              lin_mode,
  input logic [ADDR_W-1:0] addr_in,
  input logic [ADDR_W-1:0] addr_out,
  input logic              last_beat
);
  logic [OFS_W-1:0] st_q;
  logic             md_q;
  logic             seen_q;
  logic [OFS_W-1:0] cur, nx_il, nx_lin, idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= '0; md_q <= 1'b0; seen_q <= 1'b0;
    end else if (load) begin
      st_q <= addr_in[OFS_W-1:0]; md_q <= lin_mode; seen_q <= 1'b1;
    end
  end

  assign cur    = addr_out[OFS_W-1:0];
  assign nx_il  = (cur ^ st_q) + 1'b1;
  assign nx_lin = cur + 1'b1;
  assign idx    = md_q ? cur - st_q : cur ^ st_q;

  assert_load_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (addr_out == $past(addr_in)) && !last_beat);
  assert_interleave_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !load && advance && !md_q) |=> ((cur ^ st_q) == $past(nx_il)));
  assert_linear_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !load && advance && md_q) |=> (cur == $past(nx_lin)));
  assert_upper_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (addr_out[ADDR_W-1:OFS_W] == $past(addr_out[ADDR_W-1:OFS_W])));
  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !(advance && seen_q)) |=> ($stable(addr_out) && $stable(last_beat)));
  assert_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && advance && last_beat) |=> ((cur == st_q) && !last_beat));
  assert_last_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat == (seen_q && (idx == {OFS_W{1'b1}})));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .advance(advance), .lin_mode(lin_mode),
  .addr_in(addr_in), .addr_out(addr_out), .last_beat(last_beat));

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load = 1'b0, advance = 1'b0, lin_mode = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr_out;
  logic          last_beat;
  int            n_cmp = 0, n_bad = 0;
  bit            done = 1'b0;

  always #10 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW), .OFS_W(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .load(load), .advance(advance), .lin_mode(lin_mode),
    .addr_in(addr_in), .addr_out(addr_out), .last_beat(last_beat));

  task automatic chk(string req, logic [AW-1:0] ea, logic el);
    n_cmp++;
    if (addr_out !== ea || last_beat !== el) begin
      n_bad++;
      $display("FAIL %s: addr=%h last=%b expected addr=%h last=%b", req, addr_out, last_beat, ea, el);
    end
  endtask

  task automatic step(logic ld, logic adv, logic md, logic [AW-1:0] a);
    @(negedge clk);
    load = ld; advance = adv; lin_mode = md; addr_in = a;
    @(posedge clk); #5;
    load = 1'b0; advance = 1'b0;
  endtask

  function automatic logic [1:0] exp_ofs(logic md, logic [1:0] s, int b);
    return md ? 2'((int'(s) + b) % 4) : (s ^ 2'(b));
  endfunction

  initial begin
    #200000;
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] a;
    repeat (3) @(posedge clk);
    #5 chk("R1 reset", '0, 1'b0);
    rst_n = 1'b1;
    step(0, 1, 0, '0);
    chk("R7 advance before load", '0, 1'b0);
    step(0, 1, 1, 20'hFFFFF);
    chk("R7 advance before load", '0, 1'b0);

    for (int md = 0; md < 2; md++) begin
      for (int s = 0; s < 4; s++) begin
        a = {18'(md ? 18'h2AAAA : 18'h15555) ^ 18'(s * 18'h0F0F), 2'(s)};
        step(1, 0, md[0], a);
        chk(md ? "R2 R4 load linear" : "R2 R3 load interleaved", a, 1'b0);
        for (int b = 1; b <= 5; b++) begin
          step(0, 1, ~md[0], '0);
          chk(md ? "R4 R5 R8 R9 R10 linear beat" : "R3 R5 R8 R9 R10 interleaved beat",
              {a[AW-1:2], exp_ofs(md[0], 2'(s), b % 4)}, (b % 4) == 3);
        end
        step(0, 0, md[0], 20'h0);
        chk("R7 idle hold", {a[AW-1:2], exp_ofs(md[0], 2'(s), 1)}, 1'b0);
      end
    end

    a = 20'hABCD2;
    step(1, 0, 1, a);
    step(0, 1, 1, '0);
    step(0, 1, 1, '0);
    step(1, 1, 0, 20'h12343);
    chk("R6 load beats advance", 20'h12343, 1'b0);
    step(0, 1, 1, '0);
    chk("R6 R3 after priority load", 20'h12342, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule